// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master for Ethernet PHYs. Software programs a clock divider, clears the completion flag and then writes one 32-bit command word. That single write launches a complete management frame on the MDC/MDIO pins. The frame carries a 32-bit all-ones preamble followed by the command word, shifted out most significant bit first. The preamble is sent in full on every frame.

On a read, the block releases the MDIO line from the turnaround onward. It samples the PHY's sixteen data bits on the rising edges of MDC and collects them in the low half of the command register, where software reads them once the frame is done. Completion sets an event flag that software clears by writing a one to it. A status bit shows that a frame is in flight.

Top module: `mdio_master`

## Requirements
- R1: While a frame is in flight, MDIO carries 32 ones, then command bits 31 down to 0 in order, one bit per MDC period. The command fields are start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0].
- R2: The divider field D sits in bits [6:1] of the speed register at address 2, with bit 0 unused. MDC has a period of 2*D system clocks: it is low for D clocks and then high for D clocks.
- R3: When opcode [29:28] is 2'b10 (read), output-enable is low from frame bit 46 (the first turnaround bit) to the end of the frame. For any other opcode, output-enable stays high for all 64 bits.
- R4: On a read, the block samples MDIO-in at each MDC rising edge of frame bits 48 to 63. After completion, address 0 reads back the command's upper half with the captured 16 bits in [15:0], first bit received in bit 15.
- R5: The end of the 64th bit sets the event flag, bit 0 of address 1. Bit 1 of address 1 is high exactly while a frame is in flight.
- R6: Writing address 1 with bit 0 set clears the event flag. Writing it with bit 0 clear leaves the flag unchanged.
- R7: A command written while a frame is in flight is ignored. The stored word does not change, and no second frame follows.
- R8: While D is zero, a command write starts no frame, and MDC stays low.
- R9: After reset all registers read zero, and MDC, MDIO-out and output-enable are low.
- R10: Between frames, MDC and output-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 command/data, 1 event/status, 2 speed |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven by the block |
| mdioOe | output | 1 | Output-enable for mdioOut |
| mdioIn | input | 1 | Management data returned by the PHY |

## Verification
The bench targets the read turnaround, where a design that released the line one bit late would collide with the PHY, and a design that released it early would corrupt the register address. It checks the bit order of the captured read value, where a reversed shift would return a mirrored word. It covers odd and unit divider values, where a half-period counter off by one would stretch MDC. It also checks that a second command during a frame changes nothing, that a zero divider starts nothing, and that writing a zero to the event register leaves the flag set.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int CMD_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + CMD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic load;      // capture command into the transmit shifter
    logic shiftOut;  // advance transmit shifter by one bit
    logic sample;    // capture one read bit from the PHY
    logic done;      // last bit finished
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWr,
  input  logic                cmdIsRead,
  input  logic [DIV_W-1:0]    divField,
  output logic                busy,
  output logic                mdc,
  output logic                isRead,
  output logic [CNT_W-1:0]    bitCnt,
  output mdioStrobes_t        strb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLatch;
  logic             startOk;
  logic             halfEnd;

  assign startOk = cmdWr && !busy && (divField != '0);
  assign halfEnd = busy && (divCnt == divLatch - DIV_W'(1));

  always_comb begin
    strb          = '0;
    strb.load     = startOk;
    strb.sample   = halfEnd && !mdc && isRead && (bitCnt >= CNT_W'(DATA_POS));
    strb.shiftOut = halfEnd && mdc && (bitCnt >= CNT_W'(PRE_BITS)) && (bitCnt != LAST_BIT);
    strb.done     = halfEnd && mdc && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      mdc      <= 1'b0;
      isRead   <= 1'b0;
      bitCnt   <= '0;
      divCnt   <= '0;
      divLatch <= '0;
    end else if (startOk) begin
      busy     <= 1'b1;
      mdc      <= 1'b0;
      isRead   <= cmdIsRead;
      bitCnt   <= '0;
      divCnt   <= '0;
      divLatch <= divField;
    end else if (busy) begin
      if (halfEnd) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (mdc) begin
          if (bitCnt == LAST_BIT) busy <= 1'b0;
          else                    bitCnt <= bitCnt + CNT_W'(1);
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // R10
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R8
  zero_div_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && divField == '0) |=> !busy);

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !busy);
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWr,
  input  logic               busy,
  input  logic [31:0]        wrData,
  input  mdioStrobes_t       strb,
  input  logic               mdioIn,
  output logic [31:0]        dataReg,
  output logic               txBit
);
  logic [CMD_BITS-1:0] txShift;

  assign txBit = txShift[CMD_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      dataReg <= '0;
    end else begin
      if (strb.load)          txShift <= wrData;
      else if (strb.shiftOut) txShift <= {txShift[CMD_BITS-2:0], 1'b0};

      if (cmdWr && !busy)     dataReg <= wrData;
      else if (strb.sample)   dataReg[15:0] <= {dataReg[14:0], mdioIn};
    end
  end

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy && !strb.sample) |=> $stable(dataReg));

  // R4
  sample_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  logic               busy;
  logic               isRead;
  logic [CNT_W-1:0]   bitCnt;
  mdioStrobes_t       strb;
  logic [31:0]        dataReg;
  logic               txBit;
  logic               evtFlag;
  logic [DIV_W-1:0]   divField;
  logic               cmdWr;
  logic               evtWr;

  assign cmdWr = regWrEn && (regAddr == 2'd0);
  assign evtWr = regWrEn && (regAddr == 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag  <= 1'b0;
      divField <= '0;
    end else begin
      if (strb.done)                    evtFlag <= 1'b1;
      else if (evtWr && regWrData[0])   evtFlag <= 1'b0;
      if (regWrEn && regAddr == 2'd2)   divField <= regWrData[DIV_W:1];
    end
  end

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr),
    .cmdIsRead(regWrData[29:28] == OP_READ),
    .divField(divField), .busy(busy), .mdc(mdc),
    .isRead(isRead), .bitCnt(bitCnt), .strb(strb)
  );

  mdio_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .busy(busy),
    .wrData(regWrData), .strb(strb), .mdioIn(mdioIn),
    .dataReg(dataReg), .txBit(txBit)
  );

  assign mdioOut = busy && ((bitCnt < CNT_W'(PRE_BITS)) ? 1'b1 : txBit);
  assign mdioOe  = busy && !(isRead && (bitCnt >= CNT_W'(TA_POS)));

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = dataReg;
      2'd1:    regRdData = {30'd0, busy, evtFlag};
      2'd2:    regRdData = 32'({divField, 1'b0});
      default: regRdData = '0;
    endcase
  end

  // R5
  done_sets_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> evtFlag);

  // R6
  w1c_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtWr && regWrData[0] && !strb.done) |=> !evtFlag);

  // R1
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitCnt < CNT_W'(PRE_BITS)) |-> mdioOut);

  // R3
  turnaround_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && bitCnt >= CNT_W'(TA_POS)) |-> !mdioOe);

  // R10
  idle_oe_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int fails = 0;

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2.5 clk = ~clk;

  // cycle counter on the falling edge to avoid racing the MDC edge
  int cyc = 0;
  always @(negedge clk) cyc++;

  // frame monitor and PHY model
  int          riseCnt = 0;
  int          riseT0 = 0, riseT1 = 0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyVal = '0;

  always @(posedge mdc) begin
    capBits = {capBits[62:0], mdioOut};
    capOe   = {capOe[62:0], mdioOe};
    if (riseCnt == 0) riseT0 = cyc;
    if (riseCnt == 1) riseT1 = cyc;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt <= 63) mdioIn = phyVal[63 - riseCnt];
    else if (riseCnt == 47) mdioIn = 1'b0;
    else mdioIn = 1'b1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitEvent(output bit ok);
    logic [31:0] r;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      busRead(2'd1, r);
      if (r[0]) begin ok = 1'b1; break; end
    end
  endtask

  // vector table: command, divider, PHY read value
  localparam int NV = 4;
  localparam logic [31:0] V_CMD [NV] = '{32'h52821234, 32'h60860000, 32'h5FFEA5C3, 32'h6F0A0000};
  localparam int          V_DIV [NV] = '{2, 1, 3, 2};
  localparam logic [15:0] V_PHY [NV] = '{16'h0000, 16'h796D, 16'h0000, 16'h8001};

  initial begin : watchdog
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9 reset state
    busRead(2'd0, r); check("R9 data", r, 0);
    busRead(2'd1, r); check("R9 event", r, 0);
    busRead(2'd2, r); check("R9 speed", r, 0);
    check("R9 pins", {mdc, mdioOut, mdioOe}, 0);

    for (int v = 0; v < NV; v++) begin
      logic isRd;
      logic [63:0] mask;
      isRd = (V_CMD[v][29:28] == 2'b10);
      mask = isRd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
      busWrite(2'd2, 32'(V_DIV[v] << 1));
      busRead(2'd2, r); check("R2 speed readback", r, 32'(V_DIV[v] << 1));
      busWrite(2'd1, 32'h1);
      phyVal = V_PHY[v];
      riseCnt = 0;
      busWrite(2'd0, V_CMD[v]);
      busRead(2'd1, r); check("R5 busy", r[1], 1);
      waitEvent(ok);
      check("R5 event set", ok, 1);
      busRead(2'd1, r); check("R5 busy clear", r[1], 0);
      check("R1 bit count", riseCnt, 64);
      check("R1 frame bits", capBits & mask, {32'hFFFFFFFF, V_CMD[v]} & mask);
      check("R3 oe pattern", capOe, mask);
      check("R2 mdc period", riseT1 - riseT0, 2 * V_DIV[v]);
      busRead(2'd0, r);
      check("R4 readback", r, isRd ? {V_CMD[v][31:16], V_PHY[v]} : V_CMD[v]);
      check("R10 idle pins", {mdc, mdioOe}, 0);
    end

    // R6: writing zero keeps the flag, writing one clears it
    busWrite(2'd1, 32'h0);
    busRead(2'd1, r); check("R6 zero write keeps", r[0], 1);
    busWrite(2'd1, 32'h1);
    busRead(2'd1, r); check("R6 one write clears", r[0], 0);

    // R7: second command during a frame ignored
    busWrite(2'd2, 32'd4);
    riseCnt = 0;
    busWrite(2'd0, 32'h50061111);
    repeat (10) @(negedge clk);
    busWrite(2'd0, 32'h60062222);
    busRead(2'd0, r); check("R7 stored word", r, 32'h50061111);
    waitEvent(ok);
    repeat (40) @(negedge clk);
    check("R7 single frame", riseCnt, 64);
    busRead(2'd1, r); check("R7 not busy", r[1], 0);
    busWrite(2'd1, 32'h1);

    // R8: zero divider starts nothing
    busWrite(2'd2, 32'd0);
    riseCnt = 0;
    busWrite(2'd0, 32'h50063333);
    repeat (50) @(negedge clk);
    check("R8 no mdc", riseCnt, 0);
    busRead(2'd1, r); check("R8 no busy/event", r[1:0], 0);
    check("R8 mdc low", mdc, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule